// File: doc/BRIEF.md
# Tagged Reconfigurable Functional Unit

This block sits next to a processor register file as one more functional unit. It executes custom operations. The processor presents a function identifier and two register operands. If the identifier equals the tag of the configuration now loaded, the unit returns one result in the same cycle through purely combinational logic. If the identifier differs, or no configuration has been loaded, the unit raises a fault and gives no result. Trap software then loads the right configuration and reissues the instruction.

The datapath holds no data between operations. A context switch therefore needs no save or restore of the unit. The only state is the loaded configuration, which has four parts:
- an identifier tag;
- a 16-entry truth table that is applied at every bit position;
- a post-stage selector;
- a shift amount.

A separate load port writes all four parts in one cycle.

Top module: `tagged_fu`

## Requirements
- R1: After reset no configuration is loaded. Every issue (`issue_valid`=1) raises `fault` and keeps `res_valid` low, whatever the identifier.
- R2: An issue whose 11-bit `issue_fid` equals the loaded tag sets `res_valid`=1 and `fault`=0 in that same cycle.
- R3: An issue whose identifier differs from the loaded tag sets `fault`=1, `res_valid`=0 and `res_data`=0 in that same cycle. The two outputs are never high together.
- R4: With `issue_valid`=0, both `fault` and `res_valid` are 0.
- R5: Bit i of the table stage equals `cfg_lut[{b[i+1], a[i+1], b[i], a[i]}]`, with index bit 3 being b[i+1]. Bit positions wrap, so position 31 uses bit 0 as its neighbour.
- R6: `cfg_mode` selects the result:
  - 0: the table output T.
  - 1: T + a, modulo 2^32.
  - 2: T shifted left by `cfg_amt`, with zeros filled in.
  - 3: T rotated left by `cfg_amt`.
- R7: A load with `cfg_we`=1 writes the tag and all fields together, and they take effect from the next cycle. An issue in the load cycle itself still sees the previous configuration, or no configuration if there was none.
- R8: The result depends only on the present operands and configuration. Issuing the same operation again after other operations gives the same result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| issue_valid | input | 1 | Custom operation issued this cycle |
| issue_fid | input | 11 | Function identifier of the issued operation |
| issue_a | input | 32 | First register operand |
| issue_b | input | 32 | Second register operand |
| res_valid | output | 1 | Result valid (hit) |
| res_data | output | 32 | Result, zero when not valid |
| fault | output | 1 | Identifier miss, request trap |
| cfg_we | input | 1 | Configuration load strobe |
| cfg_fid | input | 11 | Identifier tag to load |
| cfg_lut | input | 16 | Per-bit truth table to load |
| cfg_mode | input | 2 | Post-stage selector to load |
| cfg_amt | input | 5 | Shift or rotate amount to load |

## Verification
Each of the four post-stage modes is swept across sixteen different truth tables. Every table is tried against three operand patterns:
- an arithmetic pseudo-random value;
- all-ones against zero;
- alternating bits.

Because the truth tables vary, any error in how the four index bits are assembled, including the wrap at the top bit, shows up as a wrong result. The shift amounts cover 0 to 31, so shifting and rotating are told apart at the extremes.

Further patterns target the tag logic:
- identifiers one bit away from the loaded tag, and the all-zero and all-one identifiers, to separate exact matching from partial matching;
- an issue in the same cycle as a load, to show when a new configuration takes effect;
- the same operation reissued after unrelated operations, to confirm that no state is kept.

// File: rtl/tagged_fu.sv
module tagged_fu #(
  parameter int W    = 32,
  parameter int IDW  = 11,
  parameter int AMTW = $clog2(W)
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            issue_valid,
  input  logic [IDW-1:0]  issue_fid,
  input  logic [W-1:0]    issue_a,
  input  logic [W-1:0]    issue_b,
  output logic            res_valid,
  output logic [W-1:0]    res_data,
  output logic            fault,
  input  logic            cfg_we,
  input  logic [IDW-1:0]  cfg_fid,
  input  logic [15:0]     cfg_lut,
  input  logic [1:0]      cfg_mode,
  input  logic [AMTW-1:0] cfg_amt
);
  logic            loaded;
  logic [IDW-1:0]  tag_q;
  logic [15:0]     lut_q;
  logic [1:0]      mode_q;
  logic [AMTW-1:0] amt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      loaded <= 1'b0;
      tag_q  <= '0;
      lut_q  <= '0;
      mode_q <= '0;
      amt_q  <= '0;
    end else if (cfg_we) begin
      loaded <= 1'b1;
      tag_q  <= cfg_fid;
      lut_q  <= cfg_lut;
      mode_q <= cfg_mode;
      amt_q  <= cfg_amt;
    end
  end

  logic [W-1:0]   tbl;
  logic [2*W-1:0] dbl;
  logic [W-1:0]   op;

  for (genvar i = 0; i < W; i++) begin : g_bit
    localparam int N = (i + 1) % W;
    assign tbl[i] = lut_q[{issue_b[N], issue_a[N], issue_b[i], issue_a[i]}];
  end

  assign dbl = {tbl, tbl} << amt_q;

  always_comb begin
    case (mode_q)
      2'd0:    op = tbl;
      2'd1:    op = tbl + issue_a;
      2'd2:    op = tbl << amt_q;
      default: op = dbl[2*W-1:W];
    endcase
  end

  logic hit;
  assign hit       = issue_valid && loaded && (issue_fid == tag_q);
  assign res_valid = hit;
  assign fault     = issue_valid && !hit;
  assign res_data  = hit ? op : '0;
endmodule

module tagged_fu_chk #(
  parameter int W    = 32,
  parameter int IDW  = 11,
  parameter int AMTW = $clog2(W)
) (
  input logic            clk,
  input logic            rst_n,
  input logic            issue_valid,
  input logic [IDW-1:0]  issue_fid,
  input logic [W-1:0]    issue_a,
  input logic [W-1:0]    issue_b,
  input logic            res_valid,
  input logic [W-1:0]    res_data,
  input logic            fault,
  input logic            cfg_we,
  input logic [IDW-1:0]  cfg_fid,
  input logic [15:0]     cfg_lut,
  input logic [1:0]      cfg_mode,
  input logic [AMTW-1:0] cfg_amt
);
  logic seen_load;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) seen_load <= 1'b0;
    else if (cfg_we) seen_load <= 1'b1;

  assert_empty_faults_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (!seen_load && issue_valid) |-> (fault && !res_valid));

  assert_fresh_hit_R2: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(cfg_we) && issue_valid && issue_fid == $past(cfg_fid)) |-> (res_valid && !fault));

  assert_excl_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(fault && res_valid));

  assert_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (res_data == '0));

  assert_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !issue_valid |-> (!fault && !res_valid));

  assert_stateless_R8: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(res_valid) && res_valid && !$past(cfg_we) && $stable(issue_a)
      && $stable(issue_b) && $stable(issue_fid)) |-> $stable(res_data));
endmodule

bind tagged_fu tagged_fu_chk #(.W(W), .IDW(IDW), .AMTW(AMTW)) u_chk (.*);

// File: tb/test_tagged_fu.sv
module test_tagged_fu;
  logic        clk = 0, rst_n = 0;
  logic        issue_valid = 0;
  logic [10:0] issue_fid = 0;
  logic [31:0] issue_a = 0, issue_b = 0;
  logic        res_valid, fault;
  logic [31:0] res_data;
  logic        cfg_we = 0;
  logic [10:0] cfg_fid = 0;
  logic [15:0] cfg_lut = 0;
  logic [1:0]  cfg_mode = 0;
  logic [4:0]  cfg_amt = 0;

  int errors = 0, checks = 0;

  always #4 clk = ~clk;

  tagged_fu i_tagged_fu (.*);

  function automatic logic [31:0] model(input logic [31:0] a, b, input logic [15:0] lut,
                                        input logic [1:0] m, input logic [4:0] s);
    logic [31:0] t;
    logic [63:0] w;
    for (int i = 0; i < 32; i++) begin
      int n = (i == 31) ? 0 : i + 1;
      int k = 8 * b[n] + 4 * a[n] + 2 * b[i] + a[i];
      t[i] = lut[k];
    end
    w = {32'd0, t} << s;
    case (m)
      2'd0: return t;
      2'd1: return t + a;
      2'd2: return w[31:0];
      default: return w[31:0] | w[63:32];
    endcase
  endfunction

  task automatic chk(input string req, input logic [33:0] got, exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got v=%b f=%b d=%h expected v=%b f=%b d=%h", req,
               got[33], got[32], got[31:0], exp[33], exp[32], exp[31:0]);
    end
  endtask

  task automatic load(input logic [10:0] id, input logic [15:0] l, input logic [1:0] m,
                      input logic [4:0] s);
    @(negedge clk);
    cfg_we = 1; cfg_fid = id; cfg_lut = l; cfg_mode = m; cfg_amt = s;
    @(negedge clk);
    cfg_we = 0;
  endtask

  task automatic issue(input logic [10:0] id, input logic [31:0] a, b);
    @(negedge clk);
    issue_valid = 1; issue_fid = id; issue_a = a; issue_b = b;
    #1;
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    logic [31:0] exp_keep;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1 chk("R4 idle after reset", {res_valid, fault, res_data}, {2'b00, 32'd0});
    issue(11'd0, 32'h1234, 32'h5678);
    chk("R1 fid 0 faults", {res_valid, fault, res_data}, {2'b01, 32'd0});
    issue(11'h7FF, 32'h1, 32'h2);
    chk("R1 fid 7FF faults", {res_valid, fault, res_data}, {2'b01, 32'd0});

    @(negedge clk);
    cfg_we = 1; cfg_fid = 11'h155; cfg_lut = 16'h6996; cfg_mode = 0; cfg_amt = 0;
    issue_valid = 1; issue_fid = 11'h155; issue_a = 32'hF0F0; issue_b = 32'h0FF0;
    #1 chk("R7 load cycle still empty", {res_valid, fault, res_data}, {2'b01, 32'd0});
    @(negedge clk);
    cfg_we = 0;
    #1 chk("R7 new config active", {res_valid, fault, res_data},
           {2'b10, model(32'hF0F0, 32'h0FF0, 16'h6996, 0, 0)});

    for (int m = 0; m < 4; m++)
      for (int k = 0; k < 16; k++) begin
        logic [15:0] l = 16'(k * 16'h1357 + m * 16'h0F1) ^ (16'h1 << k);
        logic [4:0]  s = 5'(k * 2 + m);
        logic [10:0] id = 11'(k * 131 + m * 7);
        load(id, l, 2'(m), s);
        for (int p = 0; p < 3; p++) begin
          logic [31:0] a = (p == 0) ? 32'(k * 32'h9E3779B9 + m) : (p == 1) ? 32'hFFFFFFFF : 32'hAAAAAAAA;
          logic [31:0] b = (p == 0) ? ~{a[15:0], a[31:16]} : (p == 1) ? 32'h0 : 32'h33333333;
          issue(id, a, b);
          chk(m == 0 ? "R5 table stage" : "R6 post stage", {res_valid, fault, res_data},
              {2'b10, model(a, b, l, 2'(m), s)});
        end
      end

    load(11'h2A5, 16'hE81C, 2'd3, 5'd31);
    issue(11'h2A5, 32'h80000001, 32'h7FFFFFFE);
    chk("R6 rotate by 31", {res_valid, fault, res_data},
        {2'b10, model(32'h80000001, 32'h7FFFFFFE, 16'hE81C, 3, 31)});
    exp_keep = model(32'hDEADBEEF, 32'h01234567, 16'hE81C, 3, 31);
    issue(11'h2A5, 32'hDEADBEEF, 32'h01234567);
    chk("R2 hit", {res_valid, fault, res_data}, {2'b10, exp_keep});
    issue(11'h2A4, 32'hDEADBEEF, 32'h01234567);
    chk("R3 one bit off low", {res_valid, fault, res_data}, {2'b01, 32'd0});
    issue(11'h6A5, 32'hDEADBEEF, 32'h01234567);
    chk("R3 one bit off high", {res_valid, fault, res_data}, {2'b01, 32'd0});
    issue(11'h2A5, 32'h0, 32'hFFFFFFFF);
    chk("R2 other operands", {res_valid, fault, res_data},
        {2'b10, model(32'h0, 32'hFFFFFFFF, 16'hE81C, 3, 31)});
    issue(11'h2A5, 32'hDEADBEEF, 32'h01234567);
    chk("R8 reissue same result", {res_valid, fault, res_data}, {2'b10, exp_keep});

    load(11'h7FF, 16'hFFFF, 2'd2, 5'd31);
    issue(11'h7FF, 32'h0, 32'h0);
    chk("R6 shift by 31", {res_valid, fault, res_data}, {2'b10, 32'h80000000});
    issue(11'h2A5, 32'h0, 32'h0);
    chk("R3 old tag replaced", {res_valid, fault, res_data}, {2'b01, 32'd0});
    load(11'h000, 16'hFFFF, 2'd1, 5'd0);
    issue(11'h000, 32'h1, 32'h0);
    chk("R6 add wraps", {res_valid, fault, res_data}, {2'b10, 32'h0});
    @(negedge clk);
    issue_valid = 0; issue_fid = 11'h000;
    #1 chk("R4 no issue", {res_valid, fault}, 2'b00);

    @(negedge clk);
    rst_n = 0;
    @(negedge clk);
    rst_n = 1;
    issue(11'h000, 32'h1, 32'h0);
    chk("R1 reset clears config", {res_valid, fault, res_data}, {2'b01, 32'd0});
    @(negedge clk);
    issue_valid = 0;

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule